// File: doc/BRIEF.md
# Rolling Shutter Frame Sequencer

This block sets the row timing of an electronic rolling shutter. It keeps two line pointers that sweep the array from the top row to the bottom. The reset pointer leads the read pointer by an exposure offset counted in lines. Time is divided into line periods, each a fixed number of clock cycles. At the first cycle of each period the block can issue a one-cycle line-reset strobe with its row and a one-cycle line-read strobe with its row.

A frame is made of its valid lines followed by a number of dummy lines. Dummy lines take up line periods but never produce a strobe. An acquisition begins with a priming phase: the first rows of frame 1 are reset, as many as the exposure, and no row is read. After that, each period reads one line and resets the line that lies one exposure ahead. That line may belong to the next frame. The sequence ends after the last line of the last frame has been read.

A run bit starts the sequence. A second rising edge of the run bit aborts the sequence and starts a new one. Clearing the run bit stops it, either at the end of the current line or at once when fast-stop is set. With auto-start set, a sequence that ends normally while run is still high is followed directly by a new one.

Top module: `rs_frame_seq`

## Requirements
- R1: After reset, busy=0 and idle=1 and no strobe is issued. In the cycle after the clock edge at which run is first sampled 1 (having been 0 at the previous edge), busy=1 and idle=0, and line period 0 begins.
- R2: During the first E line periods of a sequence (E = the effective exposure), rows 0..E-1 are reset in order, one per period, and no read strobe or frame-start pulse is issued.
- R3: In line period k, the reset pointer stands at position k and the read pointer at position k-E. Both count in frame lines of length L = V + D (V = valid lines, D = dummy lines). A strobe is issued only when its pointer's line within the frame is below V, with the row equal to that line. Rows therefore run top to bottom, and dummy lines produce no strobe.
- R4: The reset pointer wraps from line L-1 to line 0 of the next frame only while frames remain after the current one. Once the last frame has been reset, no further reset strobes are issued.
- R5: frame_start pulses for one cycle in each period where the read pointer is at line 0 of a frame, together with the read strobe for row 0.
- R6: With F frames requested (a request of 0 is treated as 1), the sequence lasts F*L + E line periods. busy falls at the end of the period that reads the last (dummy) line of frame F.
- R7: The effective exposure is min(exposure, L-1). A valid-line request of 0 is treated as 1.
- R8: A line period is LINE_CYC clock cycles (at least 2). Every strobe lasts exactly one cycle, in the first cycle of its period.
- R9: When run is sampled 0 with fast_stop=0, the current line period completes. busy falls at the period's end and no strobe follows.
- R10: When run is sampled 0 with fast_stop=1, busy falls in the next cycle.
- R11: A rising edge of run while busy (including while finishing a line after run was cleared) aborts the sequence. A new sequence starts with period 0, resetting row 0 and reading nothing.
- R12: If a sequence ends normally while run=1 and auto_start=1, a new sequence starts in the next cycle with period 0. With auto_start=0 the block stays idle while run stays 1.
- R13: Line counts, exposure and frame count are sampled only when a sequence starts, including an automatic restart. Changes during a sequence have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run bit; rising edge starts or restarts, low stops |
| auto_start | input | 1 | Restart automatically at normal end while run is high |
| fast_stop | input | 1 | Stop at once instead of at the end of the line |
| num_valid | input | ROW_W | Valid lines per frame |
| num_dummy | input | ROW_W | Dummy lines per frame |
| exposure | input | ROW_W+1 | Exposure in lines (offset of reset ahead of read) |
| num_frames | input | FRM_W | Frames per sequence |
| reset_stb | output | 1 | Line-reset strobe |
| reset_row | output | ROW_W | Row being reset, valid with reset_stb |
| read_stb | output | 1 | Line-read strobe |
| read_row | output | ROW_W | Row being read, valid with read_stb |
| frame_start | output | 1 | Start of readout of a frame |
| busy | output | 1 | Sequence active |
| idle | output | 1 | Sequencer idle |

## Verification
Period 0 begins in the cycle after the edge that samples the run edge. Period k's strobes appear exactly k*LINE_CYC cycles after that. The bench therefore samples once per period, at the falling edge inside the period's first cycle, and compares against a period-indexed model of both pointers. A fast stop takes effect one cycle after run is sampled low. A normal stop takes effect at the first cycle of the following period. The end of a sequence, and any automatic restart, show up at period F*L+E. The bench samples each of these at exactly that cycle, and also one cycle earlier where a still-busy state must be confirmed.

// File: rtl/rsfs_pkg.sv
package rsfs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ACTIVE = 2'd1,
    SQ_DRAIN  = 2'd2
  } sq_state_e;

  // valid-line request of zero counts as one line
  function automatic int unsigned eff_valid(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned frame_len(int unsigned v, int unsigned d);
    return eff_valid(v) + d;
  endfunction

  // exposure may not reach a whole frame
  function automatic int unsigned clamp_exp(int unsigned e, int unsigned v, int unsigned d);
    int unsigned lim;
    lim = frame_len(v, d) - 1;
    return (e > lim) ? lim : e;
  endfunction

  function automatic int unsigned eff_frames(int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/rsfs_line_timer.sv
module rsfs_line_timer #(
  parameter int unsigned LINE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  output logic period_start,
  output logic period_end
);
  localparam int unsigned LC = (LINE_CYC < 2) ? 2 : LINE_CYC;
  localparam int unsigned CW = $clog2(LC);
  localparam logic [CW-1:0] LAST = CW'(LC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !enable) cnt <= '0;
    else if (cnt == LAST)       cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign period_start = enable && (cnt == '0);
  assign period_end   = enable && (cnt == LAST);

  // R8: a period start never lasts two cycles
  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

endmodule

// File: rtl/rsfs_reset_ptr.sv
module rsfs_reset_ptr #(
  parameter int unsigned LW = 11,
  parameter int unsigned FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [LW-1:0] len,
  input  logic [FW-1:0] load_frames,
  output logic          on,
  output logic [LW-1:0] line
);
  logic [FW-1:0] rem;
  logic          at_end;
  logic          more_frames;

  assign at_end      = (line == len - LW'(1));
  assign more_frames = (rem > FW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on   <= 1'b0;
      line <= '0;
      rem  <= '0;
    end else if (load) begin
      on   <= 1'b1;
      line <= '0;
      rem  <= load_frames;
    end else if (advance && on) begin
      if (at_end) begin
        if (more_frames) begin
          line <= '0;
          rem  <= rem - 1'b1;
        end else begin
          on <= 1'b0;
        end
      end else begin
        line <= line + 1'b1;
      end
    end
  end

  // R4: the pointer never leaves the frame it is in
  p_rs_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    on |-> (line < len));

endmodule

// File: rtl/rsfs_read_ptr.sv
module rsfs_read_ptr #(
  parameter int unsigned LW = 11,
  parameter int unsigned FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [LW-1:0] len,
  input  logic [FW-1:0] load_frames,
  input  logic [LW-1:0] load_expo,
  output logic          on,
  output logic [LW-1:0] line,
  output logic          last
);
  logic [FW-1:0] rem;
  logic [LW-1:0] prime;
  logic          at_end;

  assign at_end = (line == len - LW'(1));
  assign last   = on && at_end && (rem == FW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on    <= 1'b0;
      line  <= '0;
      rem   <= '0;
      prime <= '0;
    end else if (load) begin
      on    <= (load_expo == '0);
      line  <= '0;
      rem   <= load_frames;
      prime <= load_expo;
    end else if (advance) begin
      if (!on) begin
        prime <= prime - 1'b1;
        if (prime == LW'(1)) on <= 1'b1;
      end else if (at_end) begin
        if (rem > FW'(1)) begin
          line <= '0;
          rem  <= rem - 1'b1;
        end
      end else begin
        line <= line + 1'b1;
      end
    end
  end

  // R3: the read pointer stays inside its frame
  p_rd_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    on |-> (line < len));

endmodule

// File: rtl/rs_frame_seq.sv
module rs_frame_seq
  import rsfs_pkg::*;
#(
  parameter int unsigned ROW_W    = 10,
  parameter int unsigned FRM_W    = 8,
  parameter int unsigned LINE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             auto_start,
  input  logic             fast_stop,
  input  logic [ROW_W-1:0] num_valid,
  input  logic [ROW_W-1:0] num_dummy,
  input  logic [ROW_W:0]   exposure,
  input  logic [FRM_W-1:0] num_frames,
  output logic             reset_stb,
  output logic [ROW_W-1:0] reset_row,
  output logic             read_stb,
  output logic [ROW_W-1:0] read_row,
  output logic             frame_start,
  output logic             busy,
  output logic             idle
);
  localparam int unsigned LW = ROW_W + 1;

  sq_state_e        st, st_n;
  logic             run_q;
  logic [ROW_W-1:0] v_q;
  logic [LW-1:0]    len_q, exp_q;

  logic [ROW_W-1:0] v_in;
  logic [LW-1:0]    len_in, exp_in;
  logic [FRM_W-1:0] nfr_in;

  // named internal events
  logic start_evt, auto_go, load, seq_done, active, advance;
  logic period_start, period_end;
  logic rs_on, rd_on, rd_last;
  logic [LW-1:0] rs_line, rd_line;

  always_comb begin
    v_in   = ROW_W'(eff_valid(32'(num_valid)));
    len_in = LW'(frame_len(32'(num_valid), 32'(num_dummy)));
    exp_in = LW'(clamp_exp(32'(exposure), 32'(num_valid), 32'(num_dummy)));
    nfr_in = FRM_W'(eff_frames(32'(num_frames)));
  end

  assign active    = (st != SQ_IDLE);
  assign start_evt = run && !run_q;
  assign seq_done  = (st == SQ_ACTIVE) && period_end && rd_last;
  assign auto_go   = seq_done && auto_start && run;
  assign load      = start_evt || auto_go;
  assign advance   = period_end && active;

  always_comb begin
    st_n = st;
    if (load) begin
      st_n = SQ_ACTIVE;
    end else begin
      unique case (st)
        SQ_ACTIVE: begin
          if (!run)          st_n = (fast_stop || period_end) ? SQ_IDLE : SQ_DRAIN;
          else if (seq_done) st_n = SQ_IDLE;
        end
        SQ_DRAIN: if (fast_stop || period_end) st_n = SQ_IDLE;
        default:  st_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      run_q <= 1'b0;
      v_q   <= '0;
      len_q <= '0;
      exp_q <= '0;
    end else begin
      st    <= st_n;
      run_q <= run;
      if (load) begin
        v_q   <= v_in;
        len_q <= len_in;
        exp_q <= exp_in;
      end
    end
  end

  rsfs_line_timer #(.LINE_CYC(LINE_CYC)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (load),
    .enable       (active),
    .period_start (period_start),
    .period_end   (period_end)
  );

  rsfs_reset_ptr #(.LW(LW), .FW(FRM_W)) u_rs_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .advance     (advance),
    .len         (len_q),
    .load_frames (nfr_in),
    .on          (rs_on),
    .line        (rs_line)
  );

  rsfs_read_ptr #(.LW(LW), .FW(FRM_W)) u_rd_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .advance     (advance),
    .len         (len_q),
    .load_frames (nfr_in),
    .load_expo   (exp_in),
    .on          (rd_on),
    .line        (rd_line),
    .last        (rd_last)
  );

  assign reset_stb   = active && period_start && rs_on && (rs_line < {1'b0, v_q});
  assign read_stb    = active && period_start && rd_on && (rd_line < {1'b0, v_q});
  assign frame_start = active && period_start && rd_on && (rd_line == '0);
  assign reset_row   = rs_line[ROW_W-1:0];
  assign read_row    = rd_line[ROW_W-1:0];
  assign busy        = active;
  assign idle        = !active;

  // distance of reset ahead of read, same frame or next frame
  logic [LW:0] gap_same, gap_wrap;
  assign gap_same = {1'b0, rs_line} - {1'b0, rd_line};
  assign gap_wrap = {1'b0, rs_line} + {1'b0, len_q} - {1'b0, rd_line};

  // R1: a run edge makes the block busy
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  // R2: while reads have not begun, the reset pointer is working
  p_prime_resets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_on) |-> rs_on);

  // R3: simultaneous strobes are exactly one exposure apart
  p_ptr_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_stb && read_stb) |-> ((gap_same == {1'b0, exp_q}) || (gap_wrap == {1'b0, exp_q})));

  // R7: the latched exposure stays below the frame length
  p_exp_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (exp_q < len_q));

  // R9: a pending stop ends at the line boundary
  p_drain_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SQ_DRAIN) && period_end && !start_evt) |=> idle);

  // R10: fast stop leaves the busy state at once
  p_fast_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !run && fast_stop) |=> idle);

endmodule

// File: tb/test_rs_frame_seq.sv
module test_rs_frame_seq;
  localparam int ROW_W = 6;
  localparam int FRM_W = 4;
  localparam int LC    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0, auto_start = 1'b0, fast_stop = 1'b0;
  logic [ROW_W-1:0] num_valid = '0, num_dummy = '0;
  logic [ROW_W:0]   exposure = '0;
  logic [FRM_W-1:0] num_frames = '0;
  logic             reset_stb, read_stb, frame_start, busy, idle;
  logic [ROW_W-1:0] reset_row, read_row;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rs_frame_seq #(.ROW_W(ROW_W), .FRM_W(FRM_W), .LINE_CYC(LC)) i_rs_frame_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .auto_start(auto_start), .fast_stop(fast_stop),
    .num_valid(num_valid), .num_dummy(num_dummy), .exposure(exposure), .num_frames(num_frames),
    .reset_stb(reset_stb), .reset_row(reset_row), .read_stb(read_stb), .read_row(read_row),
    .frame_start(frame_start), .busy(busy), .idle(idle)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic set_params(input int v, input int d, input int e, input int n);
    num_valid  = ROW_W'(v);
    num_dummy  = ROW_W'(d);
    exposure   = (ROW_W+1)'(e);
    num_frames = FRM_W'(n);
  endtask

  // Called at the first cycle of period 0; returns at the first cycle of period T.
  task automatic verify_periods(input int v, input int d, input int e, input int n,
                                input bit perturb, input bit end_busy);
    int ve, len, ee, ne, total;
    ve = (v == 0) ? 1 : v;
    len = ve + d;
    ee = (e > len - 1) ? len - 1 : e;
    ne = (n == 0) ? 1 : n;
    total = ne * len + ee;
    for (int k = 0; k < total; k++) begin
      int rs_f, rs_l, rs_ok, rd_ok, rd_l, fs;
      string rtag;
      rs_f  = k / len;
      rs_l  = k % len;
      rs_ok = (rs_f < ne && rs_l < ve) ? 1 : 0;
      rd_ok = 0; rd_l = 0; fs = 0;
      if (k >= ee) begin
        rd_l  = (k - ee) % len;
        rd_ok = (rd_l < ve) ? 1 : 0;
        fs    = (rd_l == 0) ? 1 : 0;
      end
      rtag = (k < ee) ? "R2" : ((k >= len) ? "R4" : "R3");
      chk(rtag, "reset strobe/row", {reset_stb, (reset_stb ? reset_row : 6'd0)},
          {rs_ok[0], (rs_ok != 0 ? 6'(rs_l) : 6'd0)});
      chk((k < ee) ? "R2" : "R3", "read strobe/row", {read_stb, (read_stb ? read_row : 6'd0)},
          {rd_ok[0], (rd_ok != 0 ? 6'(rd_l) : 6'd0)});
      chk("R5", "frame_start/busy", {frame_start, busy}, {fs[0], 1'b1});
      if (perturb && k == 2) set_params(v + 3, 0, 1, n + 4);   // R13 stimulus
      if (k == 0) begin
        @(negedge clk);
        chk("R8", "strobes in 2nd cycle", {reset_stb, read_stb, frame_start}, 0);
        repeat (LC - 1) @(negedge clk);
      end else begin
        repeat (LC) @(negedge clk);
      end
    end
    chk(end_busy ? "R12" : (perturb ? "R13" : "R6"), "busy at period T", busy, end_busy);
    chk(end_busy ? "R12" : "R6", "reset strobe at period T", reset_stb, end_busy);
    if (end_busy == 0)
      chk("R6", "no read strobe at period T", read_stb, 0);
  endtask

  task automatic run_seq(input int v, input int d, input int e, input int n, input bit perturb);
    set_params(v, d, e, n);
    run = 1'b1;
    @(negedge clk);
    verify_periods(v, d, e, n, perturb, 1'b0);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    chk("R1", "busy/idle after reset", {busy, idle}, 2'b01);
    chk("R1", "strobes after reset", {reset_stb, read_stb, frame_start}, 0);
  endtask

  task automatic t_basic;
    set_params(6, 2, 3, 2);
    run = 1'b1;
    @(negedge clk);
    chk("R1", "busy/idle after run edge", {busy, idle}, 2'b10);
    verify_periods(6, 2, 3, 2, 1'b0, 1'b0);
    repeat (2 * LC) @(negedge clk);
    chk("R12", "stays idle with run held, no auto", busy, 0);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_stop_line;
    set_params(8, 0, 2, 3);
    run = 1'b1;
    @(negedge clk);
    repeat (3 * LC) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R9", "busy while line finishes", busy, 1);
    repeat (LC - 2) @(negedge clk);
    chk("R9", "busy in last cycle of line", busy, 1);
    @(negedge clk);
    chk("R9", "idle at next period boundary", {busy, reset_stb, read_stb}, 0);
    repeat (LC) @(negedge clk);
    chk("R9", "still idle one period later", {busy, reset_stb, read_stb}, 0);
  endtask

  task automatic t_fast_stop;
    fast_stop = 1'b1;
    set_params(8, 0, 2, 3);
    run = 1'b1;
    @(negedge clk);
    repeat (2 * LC) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk("R10", "fast stop idle next cycle", {busy, idle}, 2'b01);
    fast_stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_restart;
    set_params(8, 0, 3, 3);
    run = 1'b1;
    @(negedge clk);
    repeat (4 * LC) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    chk("R11", "restart resets row 0, no read", {reset_stb, reset_row, read_stb}, {1'b1, 6'd0, 1'b0});
    verify_periods(8, 0, 3, 3, 1'b0, 1'b0);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_auto;
    auto_start = 1'b1;
    set_params(3, 1, 1, 1);
    run = 1'b1;
    @(negedge clk);
    verify_periods(3, 1, 1, 1, 1'b0, 1'b1);
    verify_periods(3, 1, 1, 1, 1'b0, 1'b1);
    fast_stop = 1'b1;
    run = 1'b0;
    @(negedge clk);
    chk("R12", "auto sequence stopped", busy, 0);
    fast_stop = 1'b0;
    auto_start = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_basic();
    run_seq(4, 1, 20, 2, 1'b0);   // R7 exposure clamp
    run_seq(0, 2, 1, 1, 1'b0);    // R7 zero valid lines
    run_seq(5, 1, 0, 1, 1'b0);    // R3 zero exposure
    run_seq(3, 1, 2, 0, 1'b0);    // R6 zero frames
    run_seq(6, 2, 3, 2, 1'b1);    // R13 inputs changed mid-run
    t_stop_line();
    t_fast_stop();
    t_restart();
    t_auto();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule